// File: doc/BRIEF.md
# Transmit Phase-Align Elastic Buffer

This block carries 10-bit transmit characters from the clock that captures them into the internal character-rate clock. The capture clock is either an externally supplied transmit clock or the reference clock, chosen by a configuration input. An 8-entry dual-clock circular buffer absorbs the fixed phase offset between the two domains. The write pointer reaches the read domain in gray code through a two-flop synchronizer.

When the reference clock captures at full rate, it is already the character clock, so the buffer is skipped and the data is registered straight into the output. In the buffered modes the read domain watches the distance between the synchronized write pointer and its own read pointer. If phase drift pushes that distance out of its safe window, a sticky error flag rises. The output then sends a fixed alarm character in place of data. Only a re-initialization command clears the flag. That command also re-centres the read pointer.

Top module: `tx_phase_align`

## Requirements
- R1: While `rstN` is low, `txErr` is 0 and `charOut` is 0.
- R2: With `clkSel`=0, characters are captured on rising `txClk` edges. When `txClk` and `charClk` have equal frequency, `charOut` presents every captured character exactly once, in capture order, one per `charClk` cycle.
- R3: With `clkSel`=1 and `rateHalf`=1, characters are captured on rising `refClk` edges and pass through the buffer with the same in-order, one-per-cycle behaviour.
- R4: With `clkSel`=1 and `rateHalf`=0, the buffer is bypassed. `charOut` equals the `txData` value present at the previous rising `charClk` edge.
- R5: For any fixed phase offset between the capture clock and `charClk`, a buffer re-initialized at that offset runs without raising `txErr`.
- R6: In a buffered mode, a drift in either direction that takes the observed fill (synchronized write pointer minus read pointer, modulo 8) to 0 or to 5 or more raises `txErr`. The flag stays high after the clocks stop drifting.
- R7: In every `charClk` cycle where `txErr` is 1, `charOut` is the alarm character 10'b1001111000. This includes the cycle in which `txErr` rises.
- R8: While `paInitN` is held low, `txErr` is cleared and held at 0. After release, the read pointer is set 2 entries behind the synchronized write pointer and characters again leave in order.
- R9: Selecting the bypass mode clears `txErr` and disables drift detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| txClk | input | 1 | External transmit capture clock |
| refClk | input | 1 | Reference clock, used for capture when `clkSel`=1 |
| charClk | input | 1 | Internal character-rate clock (read domain) |
| clkSel | input | 1 | 0: capture on `txClk`; 1: capture on `refClk` |
| rateHalf | input | 1 | 1: reference clock is half rate (buffer used); 0: full rate |
| paInitN | input | 1 | Active-low buffer re-initialization command |
| txData | input | 10 | Transmit character input |
| charOut | output | 10 | Character in the `charClk` domain |
| txErr | output | 1 | Sticky phase-drift error flag |

## Verification
The bench sweeps the capture-clock phase across a full character period in half-nanosecond steps and re-initializes at each step. It then demands an unbroken incrementing sequence. A read pointer set at the wrong distance would drop or repeat a character at some of these offsets. It drifts the transmit clock both faster and slower until the flag rises. This catches a detector that guards only one side of the window. It then stops the drift and confirms the flag stays up, which exposes a flag that clears once the fill recovers. Alarm substitution is checked from the very cycle the flag rises. The bypass mode is entered while an error is pending, which catches a design that keeps the stale flag or still reads the buffer at full rate.

// File: rtl/txpa_pkg.sv
`timescale 1ns/1ps
package txpa_pkg;
  localparam int CHAR_W = 10;
  localparam logic [CHAR_W-1:0] ALARM_CHAR = 10'b1001111000;

  // Strobes from the read-domain control to the datapath
  typedef struct packed {
    logic track;     // load read pointer from synchronized write pointer
    logic selAlarm;  // substitute the alarm character this cycle
    logic bypass;    // full-rate reference capture, buffer skipped
  } paStrobe_t;
endpackage

// File: rtl/txpa_datapath.sv
`timescale 1ns/1ps
module txpa_datapath
  import txpa_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       rstN,
  input  logic                       txClk,
  input  logic                       refClk,
  input  logic                       charClk,
  input  logic                       clkSel,
  input  logic [CHAR_W-1:0]          txData,
  input  paStrobe_t                  st,
  output logic [$clog2(DEPTH)-1:0]   fill,
  output logic [CHAR_W-1:0]          charOut
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] GAP = PTR_W'(DEPTH / 4);

  // Write domain: capture clock chosen by static configuration
  logic wrClk;
  assign wrClk = clkSel ? refClk : txClk;

  logic [CHAR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrBin, wrGray, wrNext;
  assign wrNext = wrBin + 1'b1;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrNext;
      wrGray <= wrNext ^ (wrNext >> 1);
    end
  end

  always_ff @(posedge wrClk) begin
    mem[wrBin] <= txData;
  end

  // Read domain: two-flop synchronizer for the gray write pointer
  logic [PTR_W-1:0] gSync1, gSync2, wrSyncBin, rdPtr;

  always_ff @(posedge charClk or negedge rstN) begin
    if (!rstN) begin
      gSync1 <= '0;
      gSync2 <= '0;
    end else begin
      gSync1 <= wrGray;
      gSync2 <= gSync1;
    end
  end

  for (genvar i = 0; i < PTR_W; i++) begin : g_gray2bin
    assign wrSyncBin[i] = ^gSync2[PTR_W-1:i];
  end

  assign fill = wrSyncBin - rdPtr;

  always_ff @(posedge charClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      charOut <= '0;
    end else begin
      rdPtr <= st.track ? (wrSyncBin - GAP) : (rdPtr + 1'b1);
      if (st.bypass)        charOut <= txData;
      else if (st.selAlarm) charOut <= ALARM_CHAR;
      else                  charOut <= mem[rdPtr];
    end
  end

  assert_alarm_char_R7: assert property (@(posedge charClk) disable iff (!rstN)
    (st.selAlarm && !st.bypass) |=> (charOut == ALARM_CHAR));

  assert_bypass_data_R4: assert property (@(posedge charClk) disable iff (!rstN)
    st.bypass |=> (charOut == $past(txData)));
endmodule

// File: rtl/txpa_control.sv
`timescale 1ns/1ps
module txpa_control
  import txpa_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SETTLE = 4
) (
  input  logic                      rstN,
  input  logic                      charClk,
  input  logic                      clkSel,
  input  logic                      rateHalf,
  input  logic                      paInitN,
  input  logic [$clog2(DEPTH)-1:0]  fill,
  output paStrobe_t                 st,
  output logic                      txErr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [PTR_W-1:0] HIGH_FILL = PTR_W'(DEPTH / 2 + 1);

  logic [1:0]       initSync;
  logic             initActive, tracking, bypass, collide, errNext;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge charClk or negedge rstN) begin
    if (!rstN) initSync <= 2'b11;
    else       initSync <= {initSync[0], paInitN};
  end
  assign initActive = !initSync[1];

  always_ff @(posedge charClk or negedge rstN) begin
    if (!rstN)                 settleCnt <= CNT_W'(SETTLE);
    else if (initActive)       settleCnt <= CNT_W'(SETTLE);
    else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
  end

  assign tracking = initActive || (settleCnt != '0);
  assign bypass   = clkSel && !rateHalf;
  assign collide  = (fill == '0) || (fill >= HIGH_FILL);
  assign errNext  = (bypass || initActive) ? 1'b0
                                           : (txErr || (!tracking && collide));

  always_ff @(posedge charClk or negedge rstN) begin
    if (!rstN) txErr <= 1'b0;
    else       txErr <= errNext;
  end

  assign st.track    = tracking;
  assign st.selAlarm = errNext;
  assign st.bypass   = bypass;

  assert_err_sticky_R6: assert property (@(posedge charClk) disable iff (!rstN)
    (txErr && !initActive && !bypass) |=> txErr);

  assert_init_clears_R8: assert property (@(posedge charClk) disable iff (!rstN)
    initActive |=> !txErr);

  assert_bypass_clears_R9: assert property (@(posedge charClk) disable iff (!rstN)
    bypass |=> !txErr);
endmodule

// File: rtl/tx_phase_align.sv
`timescale 1ns/1ps
module tx_phase_align
  import txpa_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SETTLE = 4
) (
  input  logic              rstN,
  input  logic              txClk,
  input  logic              refClk,
  input  logic              charClk,
  input  logic              clkSel,
  input  logic              rateHalf,
  input  logic              paInitN,
  input  logic [CHAR_W-1:0] txData,
  output logic [CHAR_W-1:0] charOut,
  output logic              txErr
);
  localparam int PTR_W = $clog2(DEPTH);

  paStrobe_t        st;
  logic [PTR_W-1:0] fill;

  txpa_datapath #(.DEPTH(DEPTH)) i_datapath (
    .rstN(rstN), .txClk(txClk), .refClk(refClk), .charClk(charClk),
    .clkSel(clkSel), .txData(txData), .st(st), .fill(fill), .charOut(charOut)
  );

  txpa_control #(.DEPTH(DEPTH), .SETTLE(SETTLE)) i_control (
    .rstN(rstN), .charClk(charClk), .clkSel(clkSel), .rateHalf(rateHalf),
    .paInitN(paInitN), .fill(fill), .st(st), .txErr(txErr)
  );
endmodule

// File: tb/test_tx_phase_align.sv
`timescale 1ns/1ps
module test_tx_phase_align;
  localparam logic [9:0] ALARM = 10'b1001111000;

  logic       rstN = 1'b0, txClk = 1'b0, refClk = 1'b0, charClk = 1'b0;
  logic       clkSel = 1'b0, rateHalf = 1'b0, paInitN = 1'b1;
  logic [9:0] txData = '0;
  logic [9:0] charOut;
  logic       txErr;
  real        txHalf = 2.0;
  int         checks = 0, fails = 0;

  tx_phase_align i_tx_phase_align (
    .rstN(rstN), .txClk(txClk), .refClk(refClk), .charClk(charClk),
    .clkSel(clkSel), .rateHalf(rateHalf), .paInitN(paInitN),
    .txData(txData), .charOut(charOut), .txErr(txErr)
  );

  always #2 charClk = ~charClk;                       // 250 MHz
  initial begin #1.1; forever #2 refClk = ~refClk; end
  initial begin #0.7; forever #(txHalf) txClk = ~txClk; end

  // Source of the character stream follows the capture clock
  logic srcClk;
  assign srcClk = (clkSel && !rateHalf) ? charClk : (clkSel ? refClk : txClk);
  always @(negedge srcClk) txData <= txData + 10'd1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge charClk);
  endtask

  task automatic initPulse();
    @(negedge charClk) paInitN = 1'b0;
    cyc(4);
    chk(txErr == 1'b0, "R8 flag low during init", txErr, 0);
    paInitN = 1'b1;
    cyc(14);
  endtask

  task automatic inOrder(input int n, input string tag);
    logic [9:0] prev;
    @(negedge charClk) prev = charOut;
    for (int i = 0; i < n; i++) begin
      @(negedge charClk);
      chk(charOut == 10'(prev + 10'd1) && !txErr, tag, charOut, 10'(prev + 10'd1));
      prev = charOut;
    end
  endtask

  task automatic shiftTx(input real d);
    @(posedge txClk); #0.5; txHalf = 2.0 + d;
    @(negedge txClk); #0.5; txHalf = 2.0;
  endtask

  task automatic driftUntilErr(input real half, input string tag);
    int n;
    txHalf = half;
    n = 0;
    while (!txErr && n < 1000) begin @(negedge charClk); n++; end
    chk(txErr == 1'b1, tag, txErr, 1);
    for (int i = 0; i < 20; i++) begin
      chk(charOut == ALARM, "R7 alarm while flagged", charOut, ALARM);
      @(negedge charClk);
    end
    txHalf = 2.0;
    cyc(40);
    chk(txErr == 1'b1, "R6 flag sticky after drift stops", txErr, 1);
    chk(charOut == ALARM, "R7 alarm persists", charOut, ALARM);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(5);
    chk(txErr == 1'b0, "R1 flag in reset", txErr, 0);
    chk(charOut == 10'd0, "R1 output in reset", charOut, 0);
    #1 rstN = 1'b1;
    cyc(16);
    inOrder(50, "R2 txClk capture in order");

    // R5: sweep phase over one full character period
    for (int k = 0; k < 8; k++) begin
      shiftTx(0.5);
      initPulse();
      inOrder(20, "R5 phase offset tolerated");
    end

    // R6/R7/R8: fast drift, sticky flag, re-initialization
    driftUntilErr(1.95, "R6 fast drift raises flag");
    initPulse();
    chk(txErr == 1'b0, "R8 flag cleared by init", txErr, 0);
    inOrder(30, "R8 resume after init");

    // R6: slow drift
    driftUntilErr(2.05, "R6 slow drift raises flag");

    // R9/R4: bypass with pending error
    clkSel = 1'b1; rateHalf = 1'b0;
    cyc(3);
    chk(txErr == 1'b0, "R9 bypass clears flag", txErr, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge charClk);
      chk(charOut == txData && !txErr, "R4 bypass direct data", charOut, txData);
    end

    // R3: half-rate reference capture through the buffer
    rateHalf = 1'b1;
    initPulse();
    inOrder(40, "R3 refClk capture in order");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule